// File: doc/BRIEF.md
# Indexed Block-Access Serial Register Slave

This block is a two-wire serial bus slave that holds a small bank of configuration bytes. It answers to the 7-bit address 1101001, so the write address byte is 0xD2 and the read address byte is 0xD3. The first byte after a write address is a command byte. Its top bit selects the access style: either a counted block transfer or a plain byte/word transfer. Its low seven bits give the register index at which the access starts. In both styles, registers are visited in ascending index order.

A read uses a combined format. The master writes the address and the command byte, issues a repeated start, and then sends the read address. In block style the slave first returns a byte count and then the register contents. In byte/word style it returns the register contents directly. The master ends a read by leaving the acknowledge slot high.

The serial clock and data lines are sampled through two-flop synchronisers on the system clock. The data line is driven through an open-drain enable: when the enable is high, the line is pulled low. The whole register bank is presented to the rest of the chip as one flat parallel bus. The protocol nominally runs at 100 kbit/s. The logic only needs the system clock to be much faster than the serial clock.

Top module: `serRegSlave`

## Requirements
- R1: The slave acknowledges address bytes 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address byte, and it ignores all bus activity after such a byte until the next start condition.
- R2: The command byte is always acknowledged. Bit 7 = 0 selects block style and bit 7 = 1 selects byte/word style. Bits 6:0 give the start index M.
- R3: In a block-style write, the first data byte is a count N. The next N bytes are written to registers M, M+1, and so on. Bytes after the N-th are acknowledged and discarded.
- R4: In a byte/word-style write, every data byte is written, starting at register M and rising by one per byte.
- R5: In a block-style read, the slave first sends the count NREG−M, or 0 when M ≥ NREG. It then sends registers M, M+1, and so on.
- R6: In a byte/word-style read, the slave sends register M, then M+1, and so on, with no count byte.
- R7: If the master does not acknowledge a read byte, the slave releases the data line. It stays silent until the next start condition.
- R8: An index of NREG or more reads as 0xFF. Writes to such an index change nothing but are still acknowledged.
- R9: The slave begins pulling the data line low only while the serial clock is low, and it samples data on the rising serial clock. A start or stop condition is recognised as a data edge while the clock is high. A stop returns the slave to idle.
- R10: After reset, every register holds 0x00 and the data line is released.
- R11: Register k appears on `regBus[8k+7:8k]` from the clock edge that writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | Open-drain pull-down enable for the data line |
| regBus | output | 8·NREG | Register bank contents, register 0 in the low byte |

## Verification
The assertions check these properties on every cycle:
- The data line is only ever seized while the clock is low.
- A rejected address never leads to an acknowledge.
- Idle means released.
- Writes at an index beyond the bank, or past the block count, leave the register bus untouched.
- The count is taken only once per command.
- Read advances climb by exactly one.

Some behaviours can only be shown by the bench's transactions, because they depend on whole byte sequences seen at the pins:
- The count byte returned ahead of block data.
- The 0xFF fill beyond the last register.
- The silence after a master's not-acknowledge.
- The contents left in the bank after mixed block and byte/word traffic.

// File: rtl/serRegPkg.sv
package serRegPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_RD
  } busState_t;

  typedef struct packed {
    logic cmdLoad;
    logic cntLoad;
    logic wrData;
    logic rdStart;
    logic rdAdvance;
  } dpStrobe_t;
endpackage

// File: rtl/serRegData.sv
module serRegData
  import serRegPkg::*;
#(
  parameter int NREG = 23
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [7:0]          rxByte,
  output logic                blockMode,
  output logic                haveCount,
  output logic [7:0]          txByte,
  output logic [NREG*8-1:0]   regBus
);
  localparam logic [7:0] LAST_IDX = 8'hFF;
  localparam logic [7:0] NREG_B   = 8'(NREG);

  logic [7:0] idx;
  logic [7:0] remaining;
  logic       sendCnt;
  logic [7:0] regFile [NREG];
  logic       inRange;
  logic       doWrite;
  logic [7:0] idxNext;
  logic [7:0] rdData;
  logic [7:0] cntByte;

  assign inRange = idx < NREG_B;
  assign doWrite = strobe.wrData && inRange && (!blockMode || remaining != 8'd0);
  assign idxNext = (idx == LAST_IDX) ? idx : idx + 8'd1;
  assign cntByte = inRange ? NREG_B - idx : 8'd0;

  always_comb begin
    rdData = 8'hFF;
    for (int k = 0; k < NREG; k++) begin
      if (idx == 8'(k)) rdData = regFile[k];
    end
  end

  assign txByte = sendCnt ? cntByte : rdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      remaining <= '0;
      sendCnt   <= 1'b0;
      blockMode <= 1'b0;
      haveCount <= 1'b0;
    end else begin
      if (strobe.cmdLoad) begin
        idx       <= {1'b0, rxByte[6:0]};
        blockMode <= ~rxByte[7];
        haveCount <= 1'b0;
        remaining <= '0;
      end
      if (strobe.cntLoad) begin
        remaining <= rxByte;
        haveCount <= 1'b1;
      end
      if (strobe.wrData) begin
        idx <= idxNext;
        if (blockMode && remaining != 8'd0) remaining <= remaining - 8'd1;
      end
      if (strobe.rdStart) sendCnt <= blockMode;
      if (strobe.rdAdvance) begin
        if (sendCnt) sendCnt <= 1'b0;
        else         idx     <= idxNext;
      end
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : gRegs
    always_ff @(posedge clk) begin
      if (!rstN)                          regFile[k] <= 8'h00;
      else if (doWrite && idx == 8'(k))   regFile[k] <= rxByte;
    end
    assign regBus[8*k +: 8] = regFile[k];
  end

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData && !inRange |=> regBus == $past(regBus)); // R8
  AST_PAST_COUNT_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData && blockMode && remaining == 8'd0 |=> $stable(regBus)); // R3
  AST_COUNT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |-> !haveCount && blockMode); // R3
  AST_READ_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAdvance && !sendCnt && idx != LAST_IDX |=> idx == $past(idx) + 8'd1); // R6
endmodule

// File: rtl/serRegCtrl.sv
module serRegCtrl
  import serRegPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       blockMode,
  input  logic       haveCount,
  input  logic [7:0] txByte,
  output logic [7:0] rxByte,
  output dpStrobe_t  strobe,
  output logic       sdaOe
);
  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD;
  logic       sclNow, sdaNow;
  logic       sclRise, sclFall, startDet, stopDet;
  busState_t  state;
  logic [3:0] bitCnt;
  logic       inAck;
  logic       masterNack;
  logic [7:0] shiftReg;
  logic       byteDone, ackEnd, addrMatch;

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclD;
  assign sclFall   = ~sclNow & sclD;
  assign startDet  = sclNow & sclD & sdaD & ~sdaNow;
  assign stopDet   = sclNow & sclD & ~sdaD & sdaNow;
  assign byteDone  = (state != ST_IDLE) && sclFall && bitCnt == 4'd8 && !inAck;
  assign ackEnd    = (state != ST_IDLE) && sclFall && inAck;
  assign addrMatch = shiftReg[7:1] == SLAVE_ADDR;
  assign rxByte    = shiftReg;

  always_comb begin
    strobe = '0;
    if (byteDone) begin
      case (state)
        ST_ADDR: strobe.rdStart   = addrMatch && shiftReg[0];
        ST_CMD:  strobe.cmdLoad   = 1'b1;
        ST_WR: begin
          if (blockMode && !haveCount) strobe.cntLoad = 1'b1;
          else                         strobe.wrData  = 1'b1;
        end
        ST_RD:   strobe.rdAdvance = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync    <= 2'b11;
      sdaSync    <= 2'b11;
      sclD       <= 1'b1;
      sdaD       <= 1'b1;
      state      <= ST_IDLE;
      bitCnt     <= '0;
      inAck      <= 1'b0;
      masterNack <= 1'b0;
      shiftReg   <= '0;
      sdaOe      <= 1'b0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclNow;
      sdaD    <= sdaNow;
      if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        inAck  <= 1'b0;
        sdaOe  <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) begin
            shiftReg <= {shiftReg[6:0], sdaNow};
            bitCnt   <= bitCnt + 4'd1;
          end else begin
            masterNack <= sdaNow;
          end
        end
        if (byteDone) begin
          inAck <= 1'b1;
          case (state)
            ST_ADDR: begin
              if (addrMatch) begin
                sdaOe <= 1'b1;
                state <= shiftReg[0] ? ST_RD : ST_CMD;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_CMD: begin
              sdaOe <= 1'b1;
              state <= ST_WR;
            end
            ST_WR:   sdaOe <= 1'b1;
            default: sdaOe <= 1'b0;
          endcase
        end else if (ackEnd) begin
          inAck  <= 1'b0;
          bitCnt <= '0;
          if (state == ST_RD) begin
            if (masterNack) begin
              state <= ST_IDLE;
              sdaOe <= 1'b0;
            end else begin
              sdaOe <= ~txByte[7];
            end
          end else begin
            sdaOe <= 1'b0;
          end
        end else if (sclFall && state == ST_RD && bitCnt != 4'd0 && bitCnt < 4'd8) begin
          sdaOe <= ~txByte[3'd7 - bitCnt[2:0]];
        end
      end
    end
  end

  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclNow); // R9
  AST_BAD_ADDR_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    byteDone && state == ST_ADDR && !addrMatch |=> !sdaOe); // R1
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !sdaOe); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R2
endmodule

// File: rtl/serRegSlave.sv
module serRegSlave #(
  parameter int         NREG       = 23,
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [NREG*8-1:0] regBus
);
  import serRegPkg::*;

  dpStrobe_t  strobe;
  logic [7:0] rxByte;
  logic [7:0] txByte;
  logic       blockMode;
  logic       haveCount;

  serRegCtrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .blockMode (blockMode),
    .haveCount (haveCount),
    .txByte    (txByte),
    .rxByte    (rxByte),
    .strobe    (strobe),
    .sdaOe     (sdaOe)
  );

  serRegData #(.NREG(NREG)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rxByte    (rxByte),
    .blockMode (blockMode),
    .haveCount (haveCount),
    .txByte    (txByte),
    .regBus    (regBus)
  );
endmodule

// File: tb/serRegSlave_tb.sv
module serRegSlave_tb;
  localparam int NREG = 23;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaBus;
  logic [NREG*8-1:0] regBus;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  logic [7:0] dataBuf [16];

  assign sdaBus = sdaDrv & ~sdaOe;

  always #10 clk = ~clk;

  serRegSlave #(.NREG(NREG)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regBus(regBus)
  );

  function automatic logic [7:0] expCount(int m);
    return (m < NREG) ? 8'(NREG - m) : 8'd0;
  endfunction

  function automatic logic [7:0] expRead(int m);
    return (m < NREG) ? model[m] : 8'hFF;
  endfunction

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic checkBus(string req);
    checks++;
    for (int k = 0; k < NREG; k++) begin
      if (regBus[8*k +: 8] !== model[k]) begin
        fails++;
        $display("FAIL %s regBus byte %0d: actual %02h expected %02h", req, k, regBus[8*k +: 8], model[k]);
        break;
      end
    end
  endtask

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; sclDrv = 1'b1; hw();
    sdaDrv = 1'b0; hw();
    sclDrv = 1'b0; hw();
  endtask

  task automatic busRepStart();
    sdaDrv = 1'b1; hw();
    sclDrv = 1'b1; hw();
    sdaDrv = 1'b0; hw();
    sclDrv = 1'b0; hw();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; hw();
    sclDrv = 1'b1; hw();
    sdaDrv = 1'b1; hw();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; hw();
      sclDrv = 1'b1; hw();
      sclDrv = 1'b0;
    end
    hw();
    sdaDrv = 1'b1; hw();
    sclDrv = 1'b1; hw();
    ackd = ~sdaBus;
    sclDrv = 1'b0; hw();
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; hw();
      sclDrv = 1'b1; hw();
      b[i] = sdaBus;
      sclDrv = 1'b0; hw();
    end
    sdaDrv = nack; hw();
    sclDrv = 1'b1; hw();
    sclDrv = 1'b0; hw();
    sdaDrv = 1'b1;
  endtask

  // R1 R2 R3 R4 R8: write transaction, block style when blk is set
  task automatic doWrite(input logic blk, input int m, input int n, input int k);
    logic a;
    busStart();
    sendByte(8'hD2, a);               check8("R1", "write address ack", 8'(a), 8'd1);
    sendByte(blk ? 8'(m) : 8'(m + 128), a); check8("R2", "command ack", 8'(a), 8'd1);
    if (blk) begin
      sendByte(8'(n), a);              check8("R3", "count ack", 8'(a), 8'd1);
    end
    for (int j = 0; j < k; j++) begin
      sendByte(dataBuf[j], a);
      check8(blk ? "R3" : "R4", "data ack", 8'(a), 8'd1);
      if ((!blk || j < n) && (m + j) < NREG) model[m + j] = dataBuf[j];
    end
    busStop();
    checkBus(blk ? "R3 R11" : "R4 R11");
  endtask

  // R5 R6 R8: combined read transaction
  task automatic doRead(input logic blk, input int m, input int k);
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(8'hD2, a);               check8("R1", "write address ack", 8'(a), 8'd1);
    sendByte(blk ? 8'(m) : 8'(m + 128), a); check8("R2", "command ack", 8'(a), 8'd1);
    busRepStart();
    sendByte(8'hD3, a);               check8("R1", "read address ack", 8'(a), 8'd1);
    if (blk) begin
      recvByte(1'b0, b);
      check8("R5", "block count", b, expCount(m));
    end
    for (int j = 0; j < k; j++) begin
      recvByte(j == k - 1, b);
      check8(blk ? "R5" : "R6", ((m + j) < NREG) ? "read data" : "R8 fill", b, expRead(m + j));
    end
    busStop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkBus("R10");
    check8("R10", "sdaOe after reset", 8'(sdaOe), 8'd0);

    // directed: block write from 0, read back
    dataBuf[0] = 8'hA5; dataBuf[1] = 8'h3C; dataBuf[2] = 8'h81;
    doWrite(1'b1, 0, 3, 3);
    doRead(1'b1, 0, 3);

    // directed: indexed block with extra bytes past the count and past the bank
    dataBuf[0] = 8'h11; dataBuf[1] = 8'h22; dataBuf[2] = 8'h33; dataBuf[3] = 8'h44;
    doWrite(1'b1, 20, 2, 4);
    doRead(1'b1, 21, 3);

    // directed: word write at last register (second byte beyond bank, R8)
    dataBuf[0] = 8'h5A; dataBuf[1] = 8'hC3;
    doWrite(1'b0, 22, 0, 2);
    doRead(1'b0, 22, 2);

    // directed: block read starting beyond the bank, count 0 and 0xFF fill
    doRead(1'b1, 30, 2);

    // directed R1: foreign addresses are ignored until next start
    busStart();
    sendByte(8'hA4, a); check8("R1", "foreign address ack", 8'(a), 8'd0);
    sendByte(8'h80, a); check8("R1", "ignored byte ack", 8'(a), 8'd0);
    sendByte(8'h55, a); check8("R1", "ignored byte ack", 8'(a), 8'd0);
    busStop();
    busStart();
    sendByte(8'hD0, a); check8("R1", "near-miss address ack", 8'(a), 8'd0);
    busStop();
    checkBus("R1");

    // directed R7: master not-acknowledge silences the slave
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h80, a);
    busRepStart();
    sendByte(8'hD3, a);
    recvByte(1'b1, b); check8("R7", "byte before nack", b, expRead(0));
    for (int i = 0; i < 18; i++) begin
      sdaDrv = 1'b1; hw();
      sclDrv = 1'b1; hw();
      check8("R7", "line after nack", 8'(sdaBus), 8'd1);
      sclDrv = 1'b0; hw();
    end
    busStop();

    // random mix
    for (int it = 0; it < 30; it++) begin
      int kind = int'($urandom_range(3, 0));
      int m = int'($urandom_range(26, 0));
      int n = int'($urandom_range(3, 0));
      int k = int'($urandom_range(4, 1));
      for (int j = 0; j < 16; j++) dataBuf[j] = 8'($urandom());
      case (kind)
        0: doWrite(1'b1, m, n, k);
        1: doWrite(1'b0, m, 0, k);
        2: doRead(1'b1, m, k);
        default: doRead(1'b0, m, k);
      endcase
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule